// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a real address by searching an in-memory hashed page table. The top four address bits pick one of sixteen segment registers. The segment ID held there, together with the page index, is hashed to find a 64-byte group of eight two-word entries. The walker reads the upper word of each entry in turn and compares it with a compare word built from the segment ID and the top of the page index. It reads the lower word only when a tag matches. If no entry in the primary group matches, it searches a second group at the complemented hash.

On a hit, a protection decode combines a key bit taken from the segment register with the entry's two protection bits. The walker then sets the entry's referenced and changed flags in memory. It does this with single-byte writes and never rewrites the whole word. The response reports a hit, a miss or a protection fault, together with the real address.

A small configuration port loads the segment registers and the table base register. Requests use a valid/ready handshake, and only one walk is in flight at a time. Memory traffic uses one request channel for word reads and byte-enabled writes, and one read-data return channel.

Top module: `hptw_walker`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. Every segment register and the table base register read as zero.
- R2: A configuration write with `cfg_sel[4]`=0 loads segment register `cfg_sel[3:0]`, and one with `cfg_sel[4]`=1 loads the table base register. A walk uses the segment register numbered by effective address bits 31:28.
- R3: The primary group address is `{base[31:16],16'h0} | (H & M)`. Here H = ({4'b0, vsid ^ page} << 6), vsid is segment bits 27:0, page is address bits 27:12, and M = {7'b0, base[8:0], 16'hFFC0}.
- R4: Entry i (0 to 7) of a group has its upper word at group+8*i and its lower word at group+8*i+4. Upper words are read in ascending order. The first one equal to the compare word `{1'b1, vsid[23:0], S, ea[27:22]}` is the hit, where S is 0 on the primary search. The lower word is read only for that entry.
- R5: The secondary search uses ~H in place of H and S=1. It runs only after all eight primary entries have missed. Missing in both groups gives status miss.
- R6: On a hit, the real address is the lower word with bits 11:0 replaced by effective address bits 11:0.
- R7: The key is segment bit 29 in user mode and segment bit 30 in supervisor mode. With code = {key, lower[1:0]}, codes 0, 1, 2 and 6 permit read and write, codes 3, 5 and 7 permit read only, and code 4 permits nothing.
- R8: `rsp_status` is 1 for a permitted hit, 3 for a hit that denies the requested access, and 2 for a miss. It is a one-cycle pulse with `rsp_valid`. For status 1 and 3, `rsp_raddr` follows R6; for a miss it is 0.
- R9: If the entry is readable and lower bit 8 (referenced) is clear, the walker writes the lower word with `mem_req_be`=4'b0010 and bit 8 set. It writes no other byte. `mem_req_be[k]` covers data bits 8k+7:8k.
- R10: On a permitted write access with lower bit 7 (changed) clear, the walker writes the lower word with `mem_req_be`=4'b0001 and bit 7 set. This comes after any referenced-bit write. A denied or read access writes no changed bit.
- R11: `req_ready` is high only while idle, so a second request cannot be accepted before the current response. A memory request holds its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Bit 4 selects the base register, else bits 3:0 pick a segment register |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access is in user mode |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 1 hit, 2 miss, 3 protection fault |
| rsp_raddr | output | 32 | Real address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 byte-enabled write, 0 word read |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_req_be | output | 4 | Write byte enables |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |

## Verification
The bench's memory model accepts every request at once and returns read data in the following cycle. Under that model, `rsp_valid` rises exactly 2P + 2H + W cycles after the accepting clock edge. P is the number of upper words read across both groups, H is 1 if a lower word was read, and W is the number of byte writes. The scoreboard stores this figure with each expected status and address. The monitor compares it with a cycle counter sampled on the falling edge. A misordered scan, a skipped secondary search or a spurious or missing flag write therefore shows up as a latency error, even when the returned address is correct.

// File: rtl/hptw_pkg.sv
`timescale 1ns/1ps
// Shared types for the hashed page table walker.
package hptw_pkg;
    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2,
        ST_PROT = 2'd3
    } walk_status_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_RD_TAG,
        W_WT_TAG,
        W_RD_PTE,
        W_WT_PTE,
        W_SET_REF,
        W_SET_CHG,
        W_RESP
    } walk_state_e;

    localparam int REF_POS = 8;
    localparam int CHG_POS = 7;
endpackage

// File: rtl/hptw_regs.sv
`timescale 1ns/1ps
// Segment register file and table base register.
// Assumes writes are not issued while a walk is in flight.
module hptw_regs #(
    parameter int SEG_COUNT = 16,
    localparam int SEG_IDX_W = $clog2(SEG_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEG_IDX_W:0]   cfg_sel,
    input  logic [31:0]          cfg_wdata,
    input  logic [SEG_IDX_W-1:0] rd_idx,
    output logic [31:0]          seg_out,
    output logic [15:0]          base_hi,
    output logic [8:0]           base_size
);
    logic [31:0] seg_q [SEG_COUNT];
    logic [24:0] base_q;
    logic        unused_cfg;

    assign unused_cfg = ^cfg_wdata[15:9];

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
        // Load one segment register when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (cfg_we && !cfg_sel[SEG_IDX_W] && cfg_sel[SEG_IDX_W-1:0] == SEG_IDX_W'(g))
                seg_q[g] <= cfg_wdata;
        end
    end

    // Load the base and size fields of the table register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (cfg_we && cfg_sel[SEG_IDX_W])
            base_q <= {cfg_wdata[31:16], cfg_wdata[8:0]};
    end

    assign seg_out   = seg_q[rd_idx];
    assign base_hi   = base_q[24:9];
    assign base_size = base_q[8:0];
endmodule

// File: rtl/hptw_hash.sv
`timescale 1ns/1ps
// Computes the group address and compare word for one search pass.
// Purely combinational; sec selects the complemented hash.
module hptw_hash (
    input  logic [27:0] vsid,
    input  logic [15:0] page,
    input  logic [15:0] base_hi,
    input  logic [8:0]  base_size,
    input  logic        sec,
    output logic [31:0] grp_addr,
    output logic [31:0] cmp_word
);
    logic [31:0] hash_raw;
    logic [31:0] hash_sel;
    logic [31:0] hash_mask;

    // Hash, optional complement, mask by the table size.
    always_comb begin
        hash_raw  = {4'b0, vsid ^ {12'b0, page}} << 6;
        hash_sel  = sec ? ~hash_raw : hash_raw;
        hash_mask = {7'b0, base_size, 16'hFFC0};
        grp_addr  = {base_hi, 16'h0000} | (hash_sel & hash_mask);
    end

    assign cmp_word = {1'b1, vsid[23:0], sec, page[15:10]};
endmodule

// File: rtl/hptw_perm.sv
`timescale 1ns/1ps
// Protection decode: segment key plus entry protection bits.
module hptw_perm (
    input  logic       key_user,
    input  logic       key_super,
    input  logic       user_mode,
    input  logic [1:0] pp,
    output logic       may_rd,
    output logic       may_wr
);
    logic [2:0] code;

    assign code = {user_mode ? key_user : key_super, pp};

    // Map the 3-bit code to read/write permission.
    always_comb begin
        case (code)
            3'd0, 3'd1, 3'd2, 3'd6: begin may_rd = 1'b1; may_wr = 1'b1; end
            3'd3, 3'd5, 3'd7:       begin may_rd = 1'b1; may_wr = 1'b0; end
            default:                begin may_rd = 1'b0; may_wr = 1'b0; end
        endcase
    end
endmodule

// File: rtl/hptw_walker.sv
`timescale 1ns/1ps
// Hashed page table walker top. One request at a time; scans the
// primary group, then the secondary group, decodes protection and
// sets referenced/changed flags with byte writes.
// Assumes configuration is quiet while a walk is in progress.
module hptw_walker
    import hptw_pkg::*;
#(
    parameter int SEG_COUNT     = 16,
    parameter int GROUP_ENTRIES = 8,
    localparam int SEG_IDX_W = $clog2(SEG_COUNT),
    localparam int ENT_IDX_W = $clog2(GROUP_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEG_IDX_W:0] cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_ea,
    input  logic               req_write,
    input  logic               req_user,
    output logic               rsp_valid,
    output logic [1:0]         rsp_status,
    output logic [31:0]        rsp_raddr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_we,
    output logic [31:0]        mem_req_addr,
    output logic [3:0]         mem_req_be,
    output logic [31:0]        mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data
);
    localparam logic [ENT_IDX_W-1:0] LAST_IDX = ENT_IDX_W'(GROUP_ENTRIES - 1);

    walk_state_e          state_q, state_d;
    walk_status_e         stat_q, stat_d;
    logic [31:0]          ea_q, ea_d;
    logic [31:0]          lo_q, lo_d;
    logic [ENT_IDX_W-1:0] idx_q, idx_d;
    logic                 wr_q, wr_d, usr_q, usr_d, sec_q, sec_d;

    logic [31:0] seg_word;
    logic [15:0] base_hi;
    logic [8:0]  base_size;
    logic [31:0] grp_addr, cmp_word, tag_addr;
    logic [1:0]  pp_cur;
    logic        perm_rd, perm_wr;
    logic        unused_seg;

    assign unused_seg = ^seg_word[31] ^ seg_word[28];

    hptw_regs #(.SEG_COUNT(SEG_COUNT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rd_idx    (ea_q[31 -: SEG_IDX_W]),
        .seg_out   (seg_word),
        .base_hi   (base_hi),
        .base_size (base_size)
    );

    hptw_hash u_hash (
        .vsid      (seg_word[27:0]),
        .page      (ea_q[27:12]),
        .base_hi   (base_hi),
        .base_size (base_size),
        .sec       (sec_q),
        .grp_addr  (grp_addr),
        .cmp_word  (cmp_word)
    );

    // Protection bits come straight from the returning word in the
    // cycle it arrives, otherwise from the captured lower word.
    assign pp_cur = (state_q == W_WT_PTE) ? mem_rsp_data[1:0] : lo_q[1:0];

    hptw_perm u_perm (
        .key_user  (seg_word[29]),
        .key_super (seg_word[30]),
        .user_mode (usr_q),
        .pp        (pp_cur),
        .may_rd    (perm_rd),
        .may_wr    (perm_wr)
    );

    assign tag_addr  = grp_addr + (32'(idx_q) << 3);
    assign req_ready = (state_q == W_IDLE);

    // Next-state and memory-request decode of the walk sequence.
    always_comb begin
        state_d = state_q;
        stat_d  = stat_q;
        ea_d    = ea_q;
        lo_d    = lo_q;
        idx_d   = idx_q;
        wr_d    = wr_q;
        usr_d   = usr_q;
        sec_d   = sec_q;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_be    = 4'b0000;
        mem_req_addr  = tag_addr;
        mem_req_wdata = lo_q;
        rsp_valid     = 1'b0;
        case (state_q)
            W_IDLE: begin
                if (req_valid) begin
                    ea_d    = req_ea;
                    wr_d    = req_write;
                    usr_d   = req_user;
                    sec_d   = 1'b0;
                    idx_d   = '0;
                    state_d = W_RD_TAG;
                end
            end
            W_RD_TAG: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = W_WT_TAG;
            end
            W_WT_TAG: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_data == cmp_word) begin
                        state_d = W_RD_PTE;
                    end else if (idx_q == LAST_IDX) begin
                        if (!sec_q) begin
                            sec_d   = 1'b1;
                            idx_d   = '0;
                            state_d = W_RD_TAG;
                        end else begin
                            stat_d  = ST_MISS;
                            state_d = W_RESP;
                        end
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = W_RD_TAG;
                    end
                end
            end
            W_RD_PTE: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tag_addr | 32'h4;
                if (mem_req_ready) state_d = W_WT_PTE;
            end
            W_WT_PTE: begin
                if (mem_rsp_valid) begin
                    lo_d   = mem_rsp_data;
                    stat_d = (!perm_rd || (wr_q && !perm_wr)) ? ST_PROT : ST_HIT;
                    if (perm_rd && !mem_rsp_data[REF_POS])
                        state_d = W_SET_REF;
                    else if (wr_q && perm_wr && !mem_rsp_data[CHG_POS])
                        state_d = W_SET_CHG;
                    else
                        state_d = W_RESP;
                end
            end
            W_SET_REF: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_be    = 4'b0010;
                mem_req_addr  = tag_addr | 32'h4;
                mem_req_wdata = lo_q | (32'h1 << REF_POS);
                if (mem_req_ready) begin
                    lo_d    = lo_q | (32'h1 << REF_POS);
                    state_d = (wr_q && perm_wr && !lo_q[CHG_POS]) ? W_SET_CHG : W_RESP;
                end
            end
            W_SET_CHG: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_be    = 4'b0001;
                mem_req_addr  = tag_addr | 32'h4;
                mem_req_wdata = lo_q | (32'h1 << CHG_POS);
                if (mem_req_ready) begin
                    lo_d    = lo_q | (32'h1 << CHG_POS);
                    state_d = W_RESP;
                end
            end
            W_RESP: begin
                rsp_valid = 1'b1;
                state_d   = W_IDLE;
            end
            default: state_d = W_IDLE;
        endcase
    end

    // Walk state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            stat_q  <= ST_NONE;
            ea_q    <= '0;
            lo_q    <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            sec_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            stat_q  <= stat_d;
            ea_q    <= ea_d;
            lo_q    <= lo_d;
            idx_q   <= idx_d;
            wr_q    <= wr_d;
            usr_q   <= usr_d;
            sec_q   <= sec_d;
        end
    end

    assign rsp_status = rsp_valid ? stat_q : ST_NONE;
    assign rsp_raddr  = (rsp_valid && stat_q != ST_MISS) ? {lo_q[31:12], ea_q[11:0]} : 32'h0;

    assert_addr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);
    assert_wr_needs_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        perm_wr |-> perm_rd);
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_single_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> $countones(mem_req_be) == 1);
    assert_ref_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && mem_req_be == 4'b0010) |-> mem_req_wdata[REF_POS]);
    assert_chg_after_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && mem_req_be == 4'b0001) |-> (mem_req_wdata[CHG_POS] && mem_req_wdata[REF_POS]));
    assert_busy_no_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));
endmodule

// File: tb/test_hptw_walker.sv
`timescale 1ns/1ps
// Scoreboard bench: walk() pushes expected status/address/latency,
// the monitor pops and compares on each response pulse.
module test_hptw_walker;
    localparam logic [1:0] S_HIT = 2'd1, S_MISS = 2'd2, S_PROT = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_ea = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_raddr;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic [3:0]  mem_req_be;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    always #4 clk = ~clk;

    hptw_walker i_hptw_walker (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_raddr(rsp_raddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int n_tests = 0, n_fail = 0, cyc = 0, t_acc = 0;
    bit done = 1'b0;
    logic [31:0] seg_m [16];
    logic [31:0] base_m = '0;
    logic [31:0] mem [int unsigned];
    logic [31:0] wtmp;
    logic [1:0]  q_st [$];
    logic [31:0] q_pa [$];
    int          q_lat [$];
    string       q_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rdw(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory: always ready, read data one cycle after acceptance.
    assign mem_req_ready = 1'b1;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid) begin
                if (!mem_req_we) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= rdw(mem_req_addr);
                end else begin
                    wtmp = rdw(mem_req_addr);
                    for (int b = 0; b < 4; b++)
                        if (mem_req_be[b]) wtmp[8*b +: 8] = mem_req_wdata[8*b +: 8];
                    mem[mem_req_addr] = wtmp;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] grp(input logic [31:0] ea, input bit sec);
        logic [31:0] s = seg_m[ea[31:28]];
        logic [31:0] h = {4'b0, s[27:0] ^ {12'b0, ea[27:12]}} << 6;
        if (sec) h = ~h;
        return {base_m[31:16], 16'h0} | (h & {7'b0, base_m[8:0], 16'hFFC0});
    endfunction

    function automatic logic [31:0] cmpw(input logic [31:0] ea, input bit sec);
        logic [31:0] s = seg_m[ea[31:28]];
        return 32'h8000_0000 | ({4'b0, s[27:0]} << 7) | (sec ? 32'h40 : 32'h0) | {26'b0, ea[27:22]};
    endfunction

    function automatic logic [31:0] lo_a(input logic [31:0] ea, input bit sec, input int idx);
        return grp(ea, sec) + 32'(8 * idx) + 32'h4;
    endfunction

    task automatic put(input logic [31:0] ea, input bit sec, input int idx, input logic [31:0] lower);
        mem[grp(ea, sec) + 32'(8 * idx)] = cmpw(ea, sec);
        mem[lo_a(ea, sec, idx)] = lower;
    endtask

    task automatic cfg(input logic [4:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel[4]) base_m = d; else seg_m[sel[3:0]] = d;
    endtask

    task automatic walk(input logic [31:0] ea, input bit wr, input bit usr,
                        input logic [1:0] st, input logic [31:0] pa, input int lat, input string tag);
        @(negedge clk);
        check(req_ready === 1'b1, {tag, " R11 idle ready"}, 32'(req_ready), 32'h1);
        req_ea = ea; req_write = wr; req_user = usr; req_valid = 1'b1;
        q_st.push_back(st); q_pa.push_back(pa); q_lat.push_back(lat); q_tag.push_back(tag);
        @(negedge clk);
        t_acc = cyc;
        req_valid = 1'b0;
        check(req_ready === 1'b0, {tag, " R11 busy"}, 32'(req_ready), 32'h0);
        while (q_st.size() != 0) @(negedge clk);
    endtask

    task automatic chk_mem(input logic [31:0] a, input logic [31:0] exp, input string tag);
        check(rdw(a) === exp, {tag, " memory word"}, rdw(a), exp);
    endtask

    // Monitor: compare each response with the scoreboard head.
    initial begin
        logic [1:0] e_st;
        logic [31:0] e_pa;
        int e_lat;
        string e_tag;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid === 1'b1) begin
                if (q_st.size() == 0) begin
                    check(1'b0, "R8 unexpected response", 32'(rsp_status), 32'h0);
                end else begin
                    e_st = q_st.pop_front(); e_pa = q_pa.pop_front();
                    e_lat = q_lat.pop_front(); e_tag = q_tag.pop_front();
                    check(rsp_status === e_st, {e_tag, " R8 status"}, 32'(rsp_status), 32'(e_st));
                    check(rsp_raddr === e_pa, {e_tag, " R6 address"}, rsp_raddr, e_pa);
                    check((cyc - t_acc) == e_lat, {e_tag, " latency"}, 32'(cyc - t_acc), 32'(e_lat));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) seg_m[i] = '0;
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1, "R1 ready in reset", 32'(req_ready), 32'h1);
        check(rsp_valid === 1'b0, "R1 no response", 32'(rsp_valid), 32'h0);
        check(mem_req_valid === 1'b0, "R1 no memory request", 32'(mem_req_valid), 32'h0);
        rst_n = 1'b1;

        // R1: zero registers give group 0; hit at entry 0, flag already set.
        put(32'h0000_0000, 1'b0, 0, 32'h0001_2100);
        walk(32'h0000_0000, 1'b0, 1'b0, S_HIT, 32'h0001_2000, 4, "R1");
        mem.delete();

        cfg(5'h10, 32'h0040_0000);
        cfg(5'h03, 32'h0000_1234);
        cfg(5'h05, 32'h2ABC_DEF0);
        cfg(5'h07, 32'h4000_0777);

        // R2 R3 R9: primary entry 0 read, referenced bit written.
        put(32'h3012_3456, 1'b0, 0, 32'h0ABC_D002);
        walk(32'h3012_3456, 1'b0, 1'b0, S_HIT, 32'h0ABC_D456, 5, "R3/R9");
        chk_mem(lo_a(32'h3012_3456, 1'b0, 0), 32'h0ABC_D102, "R9");
        mem.delete();

        // R4 R10: entry 5 hit, secondary-form decoy at 2, later duplicate at 6.
        mem[grp(32'h3045_6789, 1'b0) + 32'd16] = cmpw(32'h3045_6789, 1'b1);
        put(32'h3045_6789, 1'b0, 6, 32'h0999_9000);
        put(32'h3045_6789, 1'b0, 5, 32'h0111_1000);
        walk(32'h3045_6789, 1'b1, 1'b1, S_HIT, 32'h0111_1789, 16, "R4/R10");
        chk_mem(lo_a(32'h3045_6789, 1'b0, 5), 32'h0111_1180, "R10");
        chk_mem(lo_a(32'h3045_6789, 1'b0, 6), 32'h0999_9000, "R4");
        mem.delete();

        // R9 R10: both flags already set, no writes.
        put(32'h3000_0ABC, 1'b0, 0, 32'h0222_2181);
        walk(32'h3000_0ABC, 1'b1, 1'b0, S_HIT, 32'h0222_2ABC, 4, "R9/R10");
        chk_mem(lo_a(32'h3000_0ABC, 1'b0, 0), 32'h0222_2181, "R10");
        mem.delete();

        // R5: secondary entry 2 after a full primary miss.
        put(32'h3777_7001, 1'b1, 2, 32'h0333_3003);
        walk(32'h3777_7001, 1'b0, 1'b0, S_HIT, 32'h0333_3001, 25, "R5");
        chk_mem(lo_a(32'h3777_7001, 1'b1, 2), 32'h0333_3103, "R5");
        mem.delete();

        // R5: miss in both groups.
        walk(32'h3999_9000, 1'b0, 1'b0, S_MISS, 32'h0, 32, "R5");

        // R7 R8: user key, code 4, nothing allowed, nothing written.
        put(32'h5001_2345, 1'b0, 0, 32'h0444_0000);
        walk(32'h5001_2345, 1'b0, 1'b1, S_PROT, 32'h0444_0345, 4, "R7/R8");
        chk_mem(lo_a(32'h5001_2345, 1'b0, 0), 32'h0444_0000, "R9");
        mem.delete();

        // R7 R10: code 5 write denied, referenced still set.
        put(32'h5001_2345, 1'b0, 0, 32'h0444_4001);
        walk(32'h5001_2345, 1'b1, 1'b1, S_PROT, 32'h0444_4345, 5, "R7/R10");
        chk_mem(lo_a(32'h5001_2345, 1'b0, 0), 32'h0444_4101, "R10");
        mem.delete();

        // R7: user key ignored in supervisor mode, code 0 write.
        put(32'h5001_2345, 1'b0, 0, 32'h0444_8000);
        walk(32'h5001_2345, 1'b1, 1'b0, S_HIT, 32'h0444_8345, 6, "R7");
        chk_mem(lo_a(32'h5001_2345, 1'b0, 0), 32'h0444_8180, "R10");
        mem.delete();

        // R7: supervisor key, code 6 write.
        put(32'h7000_1010, 1'b0, 0, 32'h0555_0002);
        walk(32'h7000_1010, 1'b1, 1'b0, S_HIT, 32'h0555_0010, 6, "R7");
        chk_mem(lo_a(32'h7000_1010, 1'b0, 0), 32'h0555_0182, "R7");
        mem.delete();

        // R7: code 7 read, then code 7 write denied.
        put(32'h7000_2020, 1'b0, 0, 32'h0555_5003);
        walk(32'h7000_2020, 1'b0, 1'b0, S_HIT, 32'h0555_5020, 5, "R7");
        chk_mem(lo_a(32'h7000_2020, 1'b0, 0), 32'h0555_5103, "R9");
        walk(32'h7000_2020, 1'b1, 1'b0, S_PROT, 32'h0555_5020, 4, "R7/R8");
        chk_mem(lo_a(32'h7000_2020, 1'b0, 0), 32'h0555_5103, "R10");
        mem.delete();

        // R7: supervisor key ignored in user mode, code 2 write.
        put(32'h7000_3030, 1'b0, 0, 32'h0555_A002);
        walk(32'h7000_3030, 1'b1, 1'b1, S_HIT, 32'h0555_A030, 6, "R7");
        mem.delete();

        // R2 R3: nonzero table-size field widens the hash.
        cfg(5'h10, 32'h0080_0003);
        cfg(5'h09, 32'h0000_0055);
        put(32'h90C0_0ABC, 1'b0, 0, 32'h0666_6100);
        walk(32'h90C0_0ABC, 1'b0, 1'b0, S_HIT, 32'h0666_6ABC, 4, "R2/R3");
        mem.delete();

        // R5: last secondary entry with the widened mask.
        put(32'h90C0_1234, 1'b1, 7, 32'h0777_7101);
        walk(32'h90C0_1234, 1'b0, 1'b0, S_HIT, 32'h0777_7234, 34, "R5");
        mem.delete();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule